// File: doc/BRIEF.md
# Variable Block-Size SAD Engine

This block is one processing element of an exhaustive block-matching motion search on a 16x16 macroblock. For one candidate displacement at a time it receives one current-block pixel and the matching reference pixel per accepted cycle. Over 256 accepted pixels it builds the sixteen 4x4 sums of absolute differences. It does not go back to the pixels for the larger shapes. Those are produced by pairing and re-pairing the 4x4 sums in a merge network. The 8x4, 4x8, 8x8, 16x8, 8x16 and 16x16 sums all come from that network, so a single pass gives 41 partition costs.

For each of the 41 partitions the engine keeps the lowest cost seen since the last `start`, together with the motion vector of the candidate that produced it. The surrounding search controller presents every displacement in the window, one after another, and marks the final one. Several engines can be placed side by side as stages of a linear array, each handling a different candidate. A one-cycle `done` pulse then presents all 41 cost/vector pairs in parallel.

The control is a four-state machine:
- IDLE: no search is open.
- ACCUM: pixels are being accepted.
- MERGE: one cycle in which the merged costs are compared against the stored minima.
- DONE: the one-cycle result pulse.

The transitions are:
- `start` from any state goes to ACCUM.
- ACCUM goes to MERGE on the 256th accepted pixel.
- MERGE goes to DONE when the candidate was marked last, otherwise back to ACCUM.
- DONE goes to IDLE.

Top module: `vbs_sad_engine`

## Requirements
- R1: After reset `done` is 0, every stored partition cost is 0xFFFF (65535) and every stored vector is 0.
- R2: A `start` pulse clears every stored cost to 0xFFFF and every vector to 0, visible the cycle after the edge, and opens a search in ACCUM with the pixel count at zero.
- R3: Pixel k (0..255) of a candidate belongs to 4x4 sub-block s = k/16, with s in raster order (row s/4, column s%4) and pixels within a sub-block in raster order. Partition indices 25..40 carry the 4x4 costs, index 25+s.
- R4: Indices 9..16 carry the 8-wide by 4-tall costs, index 9+2*row+col (row 0..3, col 0..1). Indices 17..24 carry the 4-wide by 8-tall costs, index 17+4*row+col (row 0..1, col 0..3).
- R5: Index 0 is 16x16. Indices 1..2 are 16x8 (top, bottom). Indices 3..4 are 8x16 (left, right). Indices 5..8 are 8x8 in raster order. Costs up to the 16x16 maximum of 65280 are exact.
- R6: Each partition keeps the candidate with the strictly lowest cost. On equal cost the earlier candidate stays.
- R7: A vector is stored as {dx, dy}, each a 5-bit two's complement value in -16..15, with dx in the upper five bits of each 10-bit field; field p sits at bits 10p+9..10p. `mv_x`, `mv_y` and `last_cand` are sampled only with a candidate's first pixel.
- R8: A candidate is exactly 256 accepted pixels. Cycles with `pix_valid` low inside ACCUM are skipped. After the 256th pixel, one MERGE cycle ignores `pix_valid`, and the next candidate may start in the cycle after it.
- R9: `done` is high for exactly one cycle, the cycle after the MERGE of the candidate marked last, and is low at all other times.
- R10: Pixels presented in IDLE, MERGE or DONE have no effect on any stored cost or vector.
- R11: Stored costs and vectors change only at the end of a MERGE cycle or on `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new search and clears the minima |
| pix_valid | input | 1 | Current/reference pixel pair is valid |
| cur_pix | input | 8 | Current-block pixel, unsigned |
| ref_pix | input | 8 | Reference pixel for the present candidate, unsigned |
| mv_x | input | 5 | Candidate horizontal displacement, two's complement |
| mv_y | input | 5 | Candidate vertical displacement, two's complement |
| last_cand | input | 1 | Marks the final candidate of the search |
| done | output | 1 | One-cycle pulse: results are final |
| best_sad | output | 656 | 41 stored costs, 16 bits each, partition p at bits 16p+15..16p |
| best_mv | output | 410 | 41 stored vectors, 10 bits each, layout per R7 |

## Verification
A wrong sub-block accumulator shows up only at the `done` pulse that closes the search. It appears at index 25+s and in every larger partition that contains s, so the index pattern of the mismatches points to the faulty sum. A pairing mistake in the merge network corrupts only the shapes built from that pair, so 4x4 results stay right while 8x4 or 8x8 results go wrong. A state-machine slip moves the `done` pulse by a cycle or lets an ignored pixel into a sum, and the pulse position is compared each cycle around every candidate boundary. A faulty minimum comparison gives the wrong vector on tied images, where the first candidate must win everywhere.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    // Macroblock geometry: 16x16 pixels split into 4x4 sub-blocks
    localparam int MB_PIX = 256;
    localparam int SB_N   = 16;
    localparam int PART_N = 41;

    // Start index of each partition group in the result vectors
    localparam int OFF_P16X16 = 0;
    localparam int OFF_P16X8  = 1;
    localparam int OFF_P8X16  = 3;
    localparam int OFF_P8X8   = 5;
    localparam int OFF_P8X4   = 9;
    localparam int OFF_P4X8   = 17;
    localparam int OFF_P4X4   = 25;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_MERGE,
        ST_DONE
    } vbs_state_e;

endpackage

// File: rtl/vbs_absdiff_acc.sv
module vbs_absdiff_acc
    import vbs_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int SB_W  = PIX_W + 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic [PIX_W-1:0]     cur_pix,
    input  logic [PIX_W-1:0]     ref_pix,
    input  logic [7:0]           pix_idx,
    output logic [SB_N*SB_W-1:0] sb_flat
);
    logic [PIX_W-1:0] abs_d;
    logic [3:0]       sb_sel;
    logic             sb_first;

    always_comb begin
        abs_d    = (cur_pix > ref_pix) ? (cur_pix - ref_pix) : (ref_pix - cur_pix);
        sb_sel   = pix_idx[7:4];
        sb_first = (pix_idx[3:0] == 4'd0);
    end

    for (genvar g = 0; g < SB_N; g++) begin : g_sb
        logic [SB_W-1:0] acc_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (acc_en && sb_sel == 4'(g)) begin
                // first pixel of a sub-block overwrites the stale sum
                acc_q <= sb_first ? SB_W'(abs_d) : acc_q + SB_W'(abs_d);
            end
        end
        assign sb_flat[g*SB_W +: SB_W] = acc_q;
    end
endmodule

// File: rtl/vbs_merge.sv
module vbs_merge
    import vbs_pkg::*;
#(
    parameter int SB_W  = 12,
    parameter int SAD_W = 16
) (
    input  logic [SB_N*SB_W-1:0]    sb_flat,
    output logic [PART_N*SAD_W-1:0] part_flat
);
    logic [SAD_W-1:0] s44  [16];
    logic [SAD_W-1:0] h84  [8];
    logic [SAD_W-1:0] v48  [8];
    logic [SAD_W-1:0] b88  [4];
    logic [SAD_W-1:0] b168 [2];
    logic [SAD_W-1:0] b816 [2];
    logic [SAD_W-1:0] b1616;

    for (genvar g = 0; g < 16; g++) begin : g_s44
        assign s44[g] = SAD_W'(sb_flat[g*SB_W +: SB_W]);
        assign part_flat[(OFF_P4X4+g)*SAD_W +: SAD_W] = s44[g];
    end

    for (genvar g = 0; g < 8; g++) begin : g_pair
        // horizontal pair: row g/2, column g%2 of 8-wide strips
        assign h84[g] = s44[(g/2)*4 + 2*(g%2)] + s44[(g/2)*4 + 2*(g%2) + 1];
        // vertical pair: row g/4, column g%4 of 8-tall strips
        assign v48[g] = s44[(2*(g/4))*4 + (g%4)] + s44[(2*(g/4)+1)*4 + (g%4)];
        assign part_flat[(OFF_P8X4+g)*SAD_W +: SAD_W] = h84[g];
        assign part_flat[(OFF_P4X8+g)*SAD_W +: SAD_W] = v48[g];
    end

    for (genvar g = 0; g < 4; g++) begin : g_quad
        assign b88[g] = h84[(2*(g/2))*2 + (g%2)] + h84[(2*(g/2)+1)*2 + (g%2)];
        assign part_flat[(OFF_P8X8+g)*SAD_W +: SAD_W] = b88[g];
    end

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign b168[g] = b88[2*g] + b88[2*g+1];
        assign b816[g] = b88[g] + b88[g+2];
        assign part_flat[(OFF_P16X8+g)*SAD_W +: SAD_W] = b168[g];
        assign part_flat[(OFF_P8X16+g)*SAD_W +: SAD_W] = b816[g];
    end

    assign b1616 = b168[0] + b168[1];
    assign part_flat[OFF_P16X16*SAD_W +: SAD_W] = b1616;
endmodule

// File: rtl/vbs_min_track.sv
module vbs_min_track
    import vbs_pkg::*;
#(
    parameter int SAD_W = 16,
    parameter int MVP_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     upd,
    input  logic [PART_N*SAD_W-1:0]  cand_sad_flat,
    input  logic [MVP_W-1:0]         cand_mv,
    output logic [PART_N*SAD_W-1:0]  best_sad_flat,
    output logic [PART_N*MVP_W-1:0]  best_mv_flat
);
    for (genvar g = 0; g < PART_N; g++) begin : g_part
        logic [SAD_W-1:0] sad_q;
        logic [MVP_W-1:0] mv_q;
        logic [SAD_W-1:0] cand;

        assign cand = cand_sad_flat[g*SAD_W +: SAD_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sad_q <= '1;
                mv_q  <= '0;
            end else if (clear) begin
                sad_q <= '1;
                mv_q  <= '0;
            end else if (upd && cand < sad_q) begin
                // strict compare: earlier candidate wins a tie
                sad_q <= cand;
                mv_q  <= cand_mv;
            end
        end

        assign best_sad_flat[g*SAD_W +: SAD_W] = sad_q;
        assign best_mv_flat[g*MVP_W +: MVP_W]  = mv_q;
    end
endmodule

// File: rtl/vbs_sad_engine.sv
module vbs_sad_engine
    import vbs_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MV_W  = 5,
    parameter int SAD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      pix_valid,
    input  logic [PIX_W-1:0]          cur_pix,
    input  logic [PIX_W-1:0]          ref_pix,
    input  logic [MV_W-1:0]           mv_x,
    input  logic [MV_W-1:0]           mv_y,
    input  logic                      last_cand,
    output logic                      done,
    output logic [PART_N*SAD_W-1:0]   best_sad,
    output logic [PART_N*2*MV_W-1:0]  best_mv
);
    localparam int SB_W  = PIX_W + 4;
    localparam int MVP_W = 2 * MV_W;
    localparam int CNT_W = $clog2(MB_PIX);

    vbs_state_e state_q, state_d;
    logic [CNT_W-1:0] pix_cnt;
    logic [MVP_W-1:0] mv_q;
    logic             last_q;
    logic             accept;
    logic             upd;
    logic             cnt_end;
    logic [SB_N*SB_W-1:0]    sb_flat;
    logic [PART_N*SAD_W-1:0] part_flat;

    assign accept  = pix_valid && (state_q == ST_ACCUM) && !start;
    assign cnt_end = (pix_cnt == CNT_W'(MB_PIX - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ACCUM;
            ST_ACCUM: if (!start && accept && cnt_end) state_d = ST_MERGE;
            ST_MERGE: state_d = start ? ST_ACCUM : (last_q ? ST_DONE : ST_ACCUM);
            ST_DONE:  state_d = start ? ST_ACCUM : ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        done = (state_q == ST_DONE);
        upd  = (state_q == ST_MERGE) && !start;
    end

    // pixel counter and per-candidate tags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_cnt <= '0;
            mv_q    <= '0;
            last_q  <= 1'b0;
        end else if (start) begin
            pix_cnt <= '0;
        end else if (accept) begin
            pix_cnt <= pix_cnt + 1'b1;
            if (pix_cnt == '0) begin
                mv_q   <= {mv_x, mv_y};
                last_q <= last_cand;
            end
        end
    end

    vbs_absdiff_acc #(.PIX_W(PIX_W), .SB_W(SB_W)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (accept),
        .cur_pix (cur_pix),
        .ref_pix (ref_pix),
        .pix_idx (pix_cnt),
        .sb_flat (sb_flat)
    );

    vbs_merge #(.SB_W(SB_W), .SAD_W(SAD_W)) merge_i (
        .sb_flat   (sb_flat),
        .part_flat (part_flat)
    );

    vbs_min_track #(.SAD_W(SAD_W), .MVP_W(MVP_W)) min_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (start),
        .upd           (upd),
        .cand_sad_flat (part_flat),
        .cand_mv       (mv_q),
        .best_sad_flat (best_sad),
        .best_mv_flat  (best_mv)
    );
endmodule

// File: rtl/vbs_sad_engine_chk.sv
module vbs_sad_engine_chk
    import vbs_pkg::*;
#(
    parameter int SAD_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     done,
    input vbs_state_e               state,
    input logic [PART_N*SAD_W-1:0]  best_sad
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_MERGE);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (best_sad == '1));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && state != ST_MERGE) |=> $stable(best_sad));

    // R6
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (best_sad[SAD_W-1:0] <= $past(best_sad[SAD_W-1:0])));
endmodule

bind vbs_sad_engine vbs_sad_engine_chk #(.SAD_W(SAD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .state    (state_q),
    .best_sad (best_sad)
);

// File: tb/vbs_sad_engine_tb_top.sv
module vbs_sad_engine_tb_top;
    localparam int PN = 41;

    logic clk = 1'b0;
    logic rst_n, start, pix_valid, last_cand;
    logic [7:0] cur_pix, ref_pix;
    logic [4:0] mv_x, mv_y;
    logic done;
    logic [PN*16-1:0] best_sad;
    logic [PN*10-1:0] best_mv;

    always #4 clk = ~clk;

    vbs_sad_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
        .cur_pix(cur_pix), .ref_pix(ref_pix), .mv_x(mv_x), .mv_y(mv_y),
        .last_cand(last_cand), .done(done), .best_sad(best_sad), .best_mv(best_mv)
    );

    int total = 0;
    int bad   = 0;
    int cur_img [16][16];
    int ref_img [48][48];
    int exp_sad [PN];
    int exp_mx  [PN];
    int exp_my  [PN];
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFF);
    endfunction

    // partition p -> x0, y0, width, height
    task automatic geom(input int p, output int x0, output int y0, output int w, output int h);
        int q;
        if (p == 0)      begin x0 = 0; y0 = 0; w = 16; h = 16; end
        else if (p < 3)  begin x0 = 0; y0 = (p-1)*8; w = 16; h = 8; end
        else if (p < 5)  begin x0 = (p-3)*8; y0 = 0; w = 8; h = 16; end
        else if (p < 9)  begin q = p-5;  x0 = (q%2)*8; y0 = (q/2)*8; w = 8; h = 8; end
        else if (p < 17) begin q = p-9;  x0 = (q%2)*8; y0 = (q/2)*4; w = 8; h = 4; end
        else if (p < 25) begin q = p-17; x0 = (q%4)*4; y0 = (q/4)*8; w = 4; h = 8; end
        else             begin q = p-25; x0 = (q%4)*4; y0 = (q/4)*4; w = 4; h = 4; end
    endtask

    function automatic string req_of(int p);
        if (p >= 25) return "R3";
        if (p >= 9)  return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input int act, input int expv, input string what);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clear_exp();
        for (int p = 0; p < PN; p++) begin
            exp_sad[p] = 65535; exp_mx[p] = 0; exp_my[p] = 0;
        end
    endtask

    // reference: full cost straight from the pixels, strict-less update
    task automatic ref_update(input int dx, input int dy);
        int x0, y0, w, h, s, d;
        for (int p = 0; p < PN; p++) begin
            geom(p, x0, y0, w, h);
            s = 0;
            for (int y = y0; y < y0 + h; y++)
                for (int x = x0; x < x0 + w; x++) begin
                    d = cur_img[y][x] - ref_img[y+dy+16][x+dx+16];
                    s += (d < 0) ? -d : d;
                end
            if (s < exp_sad[p]) begin
                exp_sad[p] = s; exp_mx[p] = dx; exp_my[p] = dy;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        logic [9:0] f;
        for (int p = 0; p < PN; p++) begin
            f = best_mv[p*10 +: 10];
            check(tag == "" ? req_of(p) : tag, int'(best_sad[p*16 +: 16]), exp_sad[p],
                  $sformatf("sad[%0d]", p));
            check(tag == "" ? "R7" : tag, int'($signed(f[9:5])), exp_mx[p], $sformatf("dx[%0d]", p));
            check(tag == "" ? "R6" : tag, int'($signed(f[4:0])), exp_my[p], $sformatf("dy[%0d]", p));
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1; pix_valid = 1'b0;
        @(negedge clk); start = 1'b0;
        clear_exp();
        compare_all("R2");
    endtask

    // one candidate: 256 pixels with gaps, garbage tags after the first pixel
    task automatic send_cand(input int dx, input int dy, input bit last, input bit poke);
        int sb, y, x;
        for (int k = 0; k < 256; k++) begin
            if (k % 37 == 5) begin
                @(negedge clk); pix_valid = 1'b0; cur_pix = 8'hFF; ref_pix = 8'h00;
            end
            sb = k / 16;
            y = (sb / 4) * 4 + (k / 4) % 4;
            x = (sb % 4) * 4 + k % 4;
            @(negedge clk);
            check("R9", int'(done), 0, "done during pixels");
            pix_valid = 1'b1;
            cur_pix = 8'(cur_img[y][x]);
            ref_pix = 8'(ref_img[y+dy+16][x+dx+16]);
            if (k == 0) begin
                mv_x = 5'(dx); mv_y = 5'(dy); last_cand = last;
            end else begin
                mv_x = 5'(k); mv_y = 5'(k * 3); last_cand = !last;
            end
        end
        // merge cycle: optional pixel that must be ignored (R8, R10)
        @(negedge clk);
        check("R9", int'(done), 0, "done in merge");
        pix_valid = poke; cur_pix = 8'hFF; ref_pix = 8'h00; last_cand = 1'b0;
        ref_update(dx, dy);
        @(negedge clk);
        pix_valid = 1'b0;
        check("R9", int'(done), int'(last), "done after merge");
        if (last) begin
            compare_all("");
            @(negedge clk);
            check("R9", int'(done), 0, "done second cycle");
        end
    endtask

    task automatic idle_poke(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pix_valid = 1'b1; cur_pix = 8'(rnd8()); ref_pix = 8'(rnd8());
        end
        @(negedge clk); pix_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; pix_valid = 1'b0; last_cand = 1'b0;
        cur_pix = '0; ref_pix = '0; mv_x = '0; mv_y = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_exp();
        check("R1", int'(done), 0, "done at reset");
        compare_all("R1");

        // R10: pixels before any search
        idle_poke(20);
        compare_all("R10");

        // search 1: textured images, quadrants favour different vectors
        for (int y = 0; y < 48; y++)
            for (int x = 0; x < 48; x++) ref_img[y][x] = rnd8();
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                cur_img[y][x] = ref_img[y + 16 + (y < 8 ? -1 : 0)][x + 16 + (x < 8 ? 1 : 0)]
                                ^ (rnd8() % 4);
        pulse_start();
        for (int dy = -2; dy <= 1; dy++)
            for (int dx = -2; dx <= 1; dx++)
                send_cand(dx, dy, (dx == 1 && dy == 1), ((dx + dy) % 2 == 0));

        // R11 and R10: idle pixels after done leave the results alone
        idle_poke(30);
        compare_all("R11");

        // search 2: flat images, every cost ties; first vector kept (R6), extremes of the field (R7)
        for (int y = 0; y < 48; y++)
            for (int x = 0; x < 48; x++) ref_img[y][x] = 77;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++) cur_img[y][x] = 77;
        pulse_start();
        send_cand(3, -4, 1'b0, 1'b1);
        send_cand(-16, 15, 1'b0, 1'b0);
        send_cand(5, 5, 1'b1, 1'b1);

        // search 3: largest costs (R5 width), extreme vector kept alone
        for (int y = 0; y < 48; y++)
            for (int x = 0; x < 48; x++) ref_img[y][x] = 0;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++) cur_img[y][x] = 255;
        pulse_start();
        send_cand(-16, 15, 1'b1, 1'b1);

        // search 4: new texture, wider spread of displacements
        for (int y = 0; y < 48; y++)
            for (int x = 0; x < 48; x++) ref_img[y][x] = rnd8();
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                cur_img[y][x] = ref_img[y + 16 + (x < 8 ? 2 : -3)][x + 16 + (y < 8 ? -3 : 2)];
        pulse_start();
        for (int dy = -3; dy <= 2; dy += 5)
            for (int dx = -3; dx <= 2; dx++)
                send_cand(dx, dy, (dx == 2 && dy == 2), 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule